// File: doc/BRIEF.md
# Processor Bus Read/Write Cycle Controller

This block runs single memory read and write cycles for a processor over a bus with separate address, data and control lines. A requester presents an address, a direction flag and, for writes, the data to store. The controller takes the request when no cycle is running. It then steps through a fixed three-phase sequence: setup, wait and finish. During the sequence it drives the address, the outgoing data and its output enable, and the read or write strobe. At the end it raises a one-clock completion pulse.

A cycle with no wait states lasts three clocks. In the setup clock the address is placed, any write data is placed and the strobe is raised. The middle clock is the wait clock: the memory's ready line is looked at only there. Each clock that ready is low repeats the wait clock, with strobe and address held. In the finish clock the strobe is dropped and the completion pulse is given. For a read, the data bus value is taken at the edge that closes the last wait clock and is shown on the read-data output from the finish clock onward.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it is released, every bus strobe, the data output enable and the completion pulse are low, and both the bus address and the read-data output are zero.
- R2: When a request is sampled in idle with the direction flag low (read), the next clock drives the request address on the bus with the read strobe high, the write strobe low and the data output enable low.
- R3: When a request is sampled in idle with the direction flag high (write), the next clock drives the request address and the write data on the bus with the write strobe high, the read strobe low and the data output enable high.
- R4: With ready high in the wait clock, the cycle lasts exactly three clocks: setup, wait, finish. The strobe is high in the first two and low in the finish clock.
- R5: Each clock in which ready is sampled low in the wait clock adds one wait clock. During it the strobe stays high and the bus address and write data stay unchanged.
- R6: A read captures the data bus at the edge that ends the wait clock in which ready is high. The value appears on the read-data output from the finish clock and holds until the next read completes. Write cycles leave it unchanged.
- R7: The completion pulse is high for exactly one clock, the finish clock, and low at all other times.
- R8: Requests presented during setup, wait or finish clocks are ignored. After the finish clock the bus returns to idle (address zero, strobes low) unless a new request is sampled in idle.
- R9: The data output enable is high only in the setup, wait and finish clocks of a write. It is low in read cycles and in idle, and the write-data output is zero while it is low.
- R10: The read and write strobes are never high in the same clock.
- R11: The ready input has no effect outside the wait clock. A low ready in the setup clock does not lengthen the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; taken only in idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Data for a write cycle |
| req_done | output | 1 | One-clock completion pulse in the finish clock |
| rd_data | output | DATA_W | Data captured by the last completed read |
| bus_addr | output | ADDR_W | Address bus, zero in idle |
| bus_wdata | output | DATA_W | Outgoing data bus value, zero when not enabled |
| bus_data_oe | output | 1 | Output enable for the outgoing data bus |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_rdata | input | DATA_W | Incoming data bus value |
| bus_ready | input | 1 | Memory ready, looked at in the wait clock only |

## Verification
The assertions assume that the memory eventually raises ready in the wait clock. They also assume that bus_rdata is meaningful only at the edge where ready is high. Neither is checked, since an endlessly held-off cycle is legal behaviour. The stimulus therefore bounds wait states to zero through three clocks per cycle. It drives random data on bus_rdata during every wait clock except the last, so a capture on the wrong edge shows a wrong value. It also toggles ready and presents stray requests in the setup and finish clocks, so the ignored-input rules are exercised without ever leaving a cycle pending.

// File: rtl/bcc_pkg.sv
// Shared types for the bus cycle controller.
// Assumes: one cycle at a time, no bursts.
package bcc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_WAIT   = 2'd2,
        PH_FINISH = 2'd3
    } phase_e;
endpackage

// File: rtl/bcc_sequencer.sv
// Phase sequencer: idle -> setup -> wait (repeats while ready low) -> finish.
// Assumes: bus_ready is meaningful only in the wait phase.
module bcc_sequencer
    import bcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   bus_ready,
    output phase_e phase,
    output logic   accept,
    output logic   capture
);
    phase_e phase_q;
    phase_e phase_d;

    // Take a request only when no cycle runs.
    assign accept  = (phase_q == PH_IDLE) && req_valid;
    // Last wait clock: ready high closes the wait phase.
    assign capture = (phase_q == PH_WAIT) && bus_ready;
    assign phase   = phase_q;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (req_valid) phase_d = PH_SETUP;
            PH_SETUP:  phase_d = PH_WAIT;
            PH_WAIT:   if (bus_ready) phase_d = PH_FINISH;
            PH_FINISH: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    AST_ACCEPT_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> phase_q == PH_SETUP); // R2
    AST_SETUP_IGNORES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_SETUP |=> phase_q == PH_WAIT); // R11
    AST_SETUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_SETUP |-> $past(phase_q) == PH_IDLE); // R8
    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT && !bus_ready) |=> phase_q == PH_WAIT); // R5
endmodule

// File: rtl/bcc_datapath.sv
// Request holding registers and read-data capture.
// Assumes: accept and capture come from the sequencer and never coincide.
module bcc_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data
);
    // Hold the request for the length of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Take the data bus on the edge that ends the wait phase of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_data <= '0;
        else if (capture && !wr_q) rd_data <= bus_rdata;
    end

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !wr_q) |=> rd_data == $past(bus_rdata)); // R6
    AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && wr_q) |=> $stable(rd_data)); // R6
endmodule

// File: rtl/bus_cycle_ctrl.sv
// Processor-side bus cycle controller (top).
// Runs one read or write cycle of at least three clocks per request and
// stretches the middle clock while the memory is not ready.
// Assumes: a single requester; rd_data is valid from the finish clock.
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    phase_e            phase;
    logic              accept;
    logic              capture;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              in_cycle;
    logic              strobe_on;

    bcc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .phase     (phase),
        .accept    (accept),
        .capture   (capture)
    );

    bcc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_rdata (bus_rdata),
        .wr_q      (wr_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rd_data   (rd_data)
    );

    // Phase decode: the strobe covers setup and wait, and drops in finish.
    always_comb begin
        in_cycle  = (phase != PH_IDLE);
        strobe_on = (phase == PH_SETUP) || (phase == PH_WAIT);
    end

    // Bus pin drive from the held request and the current phase.
    always_comb begin
        bus_addr    = in_cycle ? addr_q : '0;
        bus_rd      = strobe_on && !wr_q;
        bus_wr      = strobe_on && wr_q;
        bus_data_oe = in_cycle && wr_q;
        bus_wdata   = (in_cycle && wr_q) ? wdata_q : '0;
        req_done    = (phase == PH_FINISH);
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R7
    AST_READY_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> req_done && !bus_rd && !bus_wr); // R4
    AST_WAIT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && !bus_ready) |=>
        ((bus_rd || bus_wr) && $stable(bus_addr) && $stable(bus_wdata))); // R5
    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !bus_rd); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R10
endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
// Bench: directed corner cases plus seeded random cycles, checked per clock.
module bus_cycle_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_data_oe;
    logic          bus_rd;
    logic          bus_wr;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_rd = '0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_data_oe(bus_data_oe), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // Expected cycle length from the wait-state count.
    function automatic int exp_len(input int waits);
        return 3 + waits;
    endfunction

    // Expected strobes packed as {rd, wr, oe} for a phase of a cycle.
    function automatic logic [2:0] exp_ctl(input bit write, input bit strobe);
        return {strobe && !write, strobe && write, write};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(bus_addr == '0, {req, " addr"}, 64'(bus_addr), 64'd0);
        chk({bus_rd, bus_wr, bus_data_oe, req_done} == 4'b0, {req, " ctl"},
            64'({bus_rd, bus_wr, bus_data_oe, req_done}), 64'd0);
        chk(bus_wdata == '0, {req, " wdata"}, 64'(bus_wdata), 64'd0);
    endtask

    // One full cycle; junk: stray requests during the cycle; rdy_setup: ready in setup.
    task automatic run_cycle(input bit write, input logic [AW-1:0] a,
                             input logic [DW-1:0] wd, input logic [DW-1:0] rdv,
                             input int waits, input bit junk, input bit rdy_setup);
        int len;
        logic [2:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = write; req_addr = a; req_wdata = wd;
        @(negedge clk);  // setup clock
        len = 1;
        e = exp_ctl(write, 1'b1);
        chk(bus_addr == a, write ? "R3 setup addr" : "R2 setup addr", 64'(bus_addr), 64'(a));
        chk({bus_rd, bus_wr, bus_data_oe} == e, write ? "R3 setup ctl" : "R2 setup ctl",
            64'({bus_rd, bus_wr, bus_data_oe}), 64'(e));
        if (write) chk(bus_wdata == wd, "R3 setup wdata", 64'(bus_wdata), 64'(wd));
        else       chk(bus_wdata == '0, "R9 read wdata zero", 64'(bus_wdata), 64'd0);
        req_valid = junk; req_write = ~write; req_addr = ~a; req_wdata = ~wd;
        bus_ready = rdy_setup;  // R11: has no effect here
        for (int w = 0; w <= waits; w++) begin
            @(negedge clk);  // wait clock
            len++;
            chk(req_done == 1'b0, "R11/R7 no early done", 64'(req_done), 64'd0);
            chk({bus_rd, bus_wr, bus_data_oe} == e, "R5 strobe held",
                64'({bus_rd, bus_wr, bus_data_oe}), 64'(e));
            chk(bus_addr == a, "R5 addr held", 64'(bus_addr), 64'(a));
            if (write) chk(bus_wdata == wd, "R5 wdata held", 64'(bus_wdata), 64'(wd));
            bus_ready = (w == waits);
            bus_rdata = (w == waits) ? rdv : $urandom;
        end
        @(negedge clk);  // finish clock
        len++;
        if (!write) exp_rd = rdv;
        chk(req_done == 1'b1, "R7 done in finish", 64'(req_done), 64'd1);
        chk(len == exp_len(waits), "R4 cycle length", 64'(len), 64'(exp_len(waits)));
        chk({bus_rd, bus_wr} == 2'b00, "R4 strobe dropped", 64'({bus_rd, bus_wr}), 64'd0);
        chk(bus_data_oe == write, "R9 oe in finish", 64'(bus_data_oe), 64'(write));
        chk(rd_data == exp_rd, "R6 read data", 64'(rd_data), 64'(exp_rd));
        bus_ready = $urandom_range(0, 1);
        bus_rdata = $urandom;
        @(negedge clk);  // back to idle: stray request must not have started a cycle
        chk_idle("R8 idle after cycle");
        chk(req_done == 1'b0, "R7 done one clock", 64'(req_done), 64'd0);
        chk(rd_data == exp_rd, "R6 rd_data held", 64'(rd_data), 64'(exp_rd));
        req_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        chk(rd_data == '0, "R1 rd_data reset", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        // Directed corners.
        run_cycle(1'b0, 16'h1234, 32'h0, 32'hCAFE_0001, 0, 1'b0, 1'b1);  // R2 R4
        run_cycle(1'b1, 16'h00F0, 32'hA5A5_5A5A, 32'h0, 0, 1'b1, 1'b1);  // R3 R8
        run_cycle(1'b0, 16'hFFFF, 32'h0, 32'h8765_4321, 3, 1'b1, 1'b0);  // R5 R11
        run_cycle(1'b1, 16'h0000, 32'hFFFF_FFFF, 32'h1111, 2, 1'b0, 1'b0); // R6 write keeps
        // Seeded random cycles.
        for (int i = 0; i < 60; i++) begin
            run_cycle(1'($urandom_range(0, 1)), AW'($urandom), $urandom, $urandom,
                      $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule